// File: doc/BRIEF.md
# DMA Transfer Counter and Completion Unit

This block governs the byte count of an information-transfer command that moves data over a byte-stream DMA port. Software writes a 16-bit transfer count as two byte registers, a low byte and a mid byte. A count of zero stands for 65536 bytes. A signed remaining-phase size is loaded while the unit is idle. Its sign gives the direction of the transfer, and its magnitude limits how much data one transfer may move. In command phase the length is capped at 32 bytes instead.

On a start pulse the unit computes the effective length and loads it into a bytes-left counter. It then requests bytes from the DMA port until the counter reaches zero, or until the data source reports that it has run short. At the end it writes the completion picture in one step. It sets the terminal-count status, records a bus-service interrupt reason, clears the sequence and flags bytes, zeroes both count registers, and raises the interrupt.

Top module: `dmac_top`

## Requirements
- R1: The transfer count is `cnt_mid*256 + cnt_lo`. A value of zero is taken as 65536.
- R2: A write to the low count register (`reg_addr`=0) or the mid count register (`reg_addr`=1) clears the terminal-count bit, `status` bit 4, at the next edge. Address 2 writes the sequence byte and address 3 writes the flags byte.
- R3: When `cmd_phase` is high at the start, the effective length is min(count, 32) and the phase size is left unchanged.
- R4: Otherwise the effective length is min(count, |phase_size|). `phase_size` is a two's-complement value of PHASE_W bits, loaded from `phase_val` by `phase_ld` while idle.
- R5: A start accepted while idle sets `busy`, loads `bytes_left` with the effective length and clears `status` bit 4, all at the next edge. `dma_req` is high while busy with `bytes_left` non-zero.
- R6: Each edge on which `dma_req` and `dma_ack` are both high moves one byte and decrements `bytes_left`. In data phase a negative phase size (`dma_dir`=1, toward the device) is incremented per byte. A non-negative one (`dma_dir`=0) is decremented.
- R7: A busy unit with `bytes_left`=0 completes at the next edge. At that edge `done` pulses for one cycle, `busy` falls, `status` becomes 0x90 (bit 7 interrupt, bit 4 terminal count), `int_reason` becomes 0x10, `irq` rises, and the sequence, flags, low count and mid count bytes become zero.
- R8: `src_short` high while busy completes the transfer at that edge, as R7. A byte acknowledged on the same edge still counts.
- R9: A start while busy is ignored. `bytes_left`, `dma_dir` and the transfer in progress are unchanged.
- R10: `irq_ack` clears `status` bit 7 and `irq` at the next edge. It leaves `int_reason` as it was.
- R11: After reset `busy`, `done`, `irq`, `status`, `int_reason`, `bytes_left`, `phase_size` and every register byte are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 count low, 1 count mid, 2 sequence, 3 flags |
| reg_wdata | input | 8 | Register write data |
| phase_ld | input | 1 | Load phase size (idle only) |
| phase_val | input | PHASE_W | Signed phase size to load |
| cmd_phase | input | 1 | Transfer belongs to command phase |
| start | input | 1 | Start transfer pulse |
| dma_req | output | 1 | Byte request to DMA port |
| dma_ack | input | 1 | DMA port accepts or supplies a byte |
| dma_dir | output | 1 | 1 toward the device, 0 from it |
| src_short | input | 1 | Data source has no further bytes |
| irq_ack | input | 1 | Interrupt acknowledge |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Interrupt line |
| bytes_left | output | 17 | Bytes still to move |
| phase_size | output | PHASE_W | Signed remaining phase size |
| status | output | 8 | Bit 7 interrupt, bit 4 terminal count |
| int_reason | output | 8 | Interrupt reason |
| seq_val | output | 8 | Sequence byte |
| flags_val | output | 8 | Flags byte |
| cnt_lo | output | 8 | Count low byte |
| cnt_mid | output | 8 | Count mid byte |

## Verification
Every result is one register stage away from its cause. A register write, a start, an acknowledged byte, a short-source flag or an interrupt acknowledge shows its effect right after the next rising edge. Completion with a zero counter appears one edge after the edge that moved the last byte. The bench changes inputs one time unit after a rising edge and samples outputs one time unit after the following edge. Each check therefore sees exactly the edge it reasons about, and the bench counts the acknowledged edges to predict when `done` falls due.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int LEN_W  = CNT_W + 1;

  typedef enum logic [1:0] {
    SEL_CNT_LO  = 2'd0,
    SEL_CNT_MID = 2'd1,
    SEL_SEQ     = 2'd2,
    SEL_FLAGS   = 2'd3
  } reg_sel_e;

  localparam logic [BYTE_W-1:0] REASON_BUS_SVC = 8'h10;
endpackage

// File: rtl/dmac_count_regs.sv
module dmac_count_regs
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              clr,
  output logic              cnt_written,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_mid,
  output logic [BYTE_W-1:0] seq_q,
  output logic [BYTE_W-1:0] flags_q
);
  logic [BYTE_W-1:0] lo_n, mid_n, seq_n, flags_n;
  reg_sel_e sel;

  assign sel         = reg_sel_e'(wr_addr);
  assign cnt_written = wr_en && (sel == SEL_CNT_LO || sel == SEL_CNT_MID);

  always_comb begin
    lo_n    = cnt_lo;
    mid_n   = cnt_mid;
    seq_n   = seq_q;
    flags_n = flags_q;
    if (wr_en) begin
      case (sel)
        SEL_CNT_LO:  lo_n    = wr_data;
        SEL_CNT_MID: mid_n   = wr_data;
        SEL_SEQ:     seq_n   = wr_data;
        SEL_FLAGS:   flags_n = wr_data;
        default:     ;
      endcase
    end
    if (clr) begin
      lo_n    = '0;
      mid_n   = '0;
      seq_n   = '0;
      flags_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo  <= '0;
      cnt_mid <= '0;
      seq_q   <= '0;
      flags_q <= '0;
    end else begin
      cnt_lo  <= lo_n;
      cnt_mid <= mid_n;
      seq_q   <= seq_n;
      flags_q <= flags_n;
    end
  end

  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_lo == '0 && cnt_mid == '0 && seq_q == '0 && flags_q == '0));
endmodule

// File: rtl/dmac_len_clamp.sv
module dmac_len_clamp
  import dmac_pkg::*;
#(
  parameter int PHASE_W = 18,
  parameter int CMD_CAP = 32
)(
  input  logic [BYTE_W-1:0]  cnt_lo,
  input  logic [BYTE_W-1:0]  cnt_mid,
  input  logic               cmd_phase,
  input  logic [PHASE_W-1:0] phase_size,
  output logic [LEN_W-1:0]   eff_len,
  output logic               to_dev
);
  localparam int CMP_W = (LEN_W > PHASE_W) ? LEN_W : PHASE_W;

  logic [LEN_W-1:0]   raw_cnt, tot_cnt;
  logic [PHASE_W-1:0] mag;
  logic [CMP_W-1:0]   tot_ext, cap_ext, min_ext;

  assign to_dev  = phase_size[PHASE_W-1];
  assign raw_cnt = {1'b0, cnt_mid, cnt_lo};
  assign tot_cnt = (raw_cnt == '0) ? {1'b1, {CNT_W{1'b0}}} : raw_cnt;
  assign mag     = to_dev ? (~phase_size + {{(PHASE_W-1){1'b0}}, 1'b1}) : phase_size;

  always_comb begin
    tot_ext = CMP_W'(tot_cnt);
    cap_ext = cmd_phase ? CMP_W'(CMD_CAP) : CMP_W'(mag);
    min_ext = (tot_ext < cap_ext) ? tot_ext : cap_ext;
    eff_len = LEN_W'(min_ext);
  end
endmodule

// File: rtl/dmac_xfer_engine.sv
module dmac_xfer_engine
  import dmac_pkg::*;
#(
  parameter int PHASE_W = 18
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LEN_W-1:0]   eff_len,
  input  logic               to_dev_in,
  input  logic               cmd_phase,
  input  logic               phase_ld,
  input  logic [PHASE_W-1:0] phase_val,
  input  logic               dma_ack,
  input  logic               src_short,
  output logic               dma_req,
  output logic               dma_dir,
  output logic               busy,
  output logic [LEN_W-1:0]   bytes_left,
  output logic [PHASE_W-1:0] phase_size,
  output logic               start_acc,
  output logic               cmpl,
  output logic               done
);
  localparam logic [LEN_W-1:0]   ONE_L = {{(LEN_W-1){1'b0}}, 1'b1};
  localparam logic [PHASE_W-1:0] ONE_P = {{(PHASE_W-1){1'b0}}, 1'b1};

  logic               busy_n, dir_n, cmdq, cmd_n, done_n, move;
  logic [LEN_W-1:0]   left_n;
  logic [PHASE_W-1:0] ph_n;

  assign dma_req   = busy && (bytes_left != '0);
  assign move      = dma_req && dma_ack;
  assign start_acc = start && !busy;
  assign cmpl      = busy && (bytes_left == '0 || src_short);

  always_comb begin
    busy_n = busy;
    left_n = bytes_left;
    ph_n   = phase_size;
    dir_n  = dma_dir;
    cmd_n  = cmdq;
    done_n = 1'b0;
    if (!busy) begin
      if (phase_ld) ph_n = phase_val;
      if (start) begin
        busy_n = 1'b1;
        left_n = eff_len;
        dir_n  = to_dev_in;
        cmd_n  = cmd_phase;
      end
    end else begin
      if (move) begin
        left_n = bytes_left - ONE_L;
        if (!cmdq) ph_n = dma_dir ? (phase_size + ONE_P) : (phase_size - ONE_P);
      end
      if (cmpl) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      bytes_left <= '0;
      phase_size <= '0;
      dma_dir    <= 1'b0;
      cmdq       <= 1'b0;
      done       <= 1'b0;
    end else begin
      busy       <= busy_n;
      bytes_left <= left_n;
      phase_size <= ph_n;
      dma_dir    <= dir_n;
      cmdq       <= cmd_n;
      done       <= done_n;
    end
  end

  a_r6_byte_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dma_req && dma_ack) |=> (bytes_left == $past(bytes_left) - ONE_L));
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmpl) |=> (busy && bytes_left <= $past(bytes_left) && $stable(dma_dir)));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/dmac_status.sv
module dmac_status
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_written,
  input  logic              start_acc,
  input  logic              cmpl,
  input  logic              irq_ack,
  output logic [BYTE_W-1:0] status,
  output logic [BYTE_W-1:0] int_reason,
  output logic              irq
);
  logic tc_q, tc_n, int_q, int_n;
  logic [BYTE_W-1:0] reason_n;

  always_comb begin
    tc_n     = tc_q;
    int_n    = int_q;
    reason_n = int_reason;
    if (start_acc || cnt_written) tc_n = 1'b0;
    if (irq_ack) int_n = 1'b0;
    if (cmpl) begin
      tc_n     = 1'b1;
      int_n    = 1'b1;
      reason_n = REASON_BUS_SVC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q       <= 1'b0;
      int_q      <= 1'b0;
      int_reason <= '0;
    end else begin
      tc_q       <= tc_n;
      int_q      <= int_n;
      int_reason <= reason_n;
    end
  end

  assign status = {int_q, 2'b00, tc_q, 4'b0000};
  assign irq    = int_q;

  a_r2_cnt_write_clears_tc: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_written && !cmpl) |=> !status[4]);
  a_r10_ack_clears_int: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !cmpl) |=> (!irq && $stable(int_reason)));
endmodule

// File: rtl/dmac_top.sv
module dmac_top
  import dmac_pkg::*;
#(
  parameter int PHASE_W = 18,
  parameter int CMD_CAP = 32
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  input  logic               phase_ld,
  input  logic [PHASE_W-1:0] phase_val,
  input  logic               cmd_phase,
  input  logic               start,
  output logic               dma_req,
  input  logic               dma_ack,
  output logic               dma_dir,
  input  logic               src_short,
  input  logic               irq_ack,
  output logic               busy,
  output logic               done,
  output logic               irq,
  output logic [16:0]        bytes_left,
  output logic [PHASE_W-1:0] phase_size,
  output logic [7:0]         status,
  output logic [7:0]         int_reason,
  output logic [7:0]         seq_val,
  output logic [7:0]         flags_val,
  output logic [7:0]         cnt_lo,
  output logic [7:0]         cnt_mid
);
  logic             cnt_written, start_acc, cmpl, to_dev;
  logic [LEN_W-1:0] eff_len;

  dmac_count_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .clr(cmpl), .cnt_written(cnt_written),
    .cnt_lo(cnt_lo), .cnt_mid(cnt_mid), .seq_q(seq_val), .flags_q(flags_val)
  );

  dmac_len_clamp #(.PHASE_W(PHASE_W), .CMD_CAP(CMD_CAP)) u_clamp (
    .cnt_lo(cnt_lo), .cnt_mid(cnt_mid), .cmd_phase(cmd_phase),
    .phase_size(phase_size), .eff_len(eff_len), .to_dev(to_dev)
  );

  dmac_xfer_engine #(.PHASE_W(PHASE_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .eff_len(eff_len),
    .to_dev_in(to_dev), .cmd_phase(cmd_phase), .phase_ld(phase_ld),
    .phase_val(phase_val), .dma_ack(dma_ack), .src_short(src_short),
    .dma_req(dma_req), .dma_dir(dma_dir), .busy(busy),
    .bytes_left(bytes_left), .phase_size(phase_size),
    .start_acc(start_acc), .cmpl(cmpl), .done(done)
  );

  dmac_status u_stat (
    .clk(clk), .rst_n(rst_n), .cnt_written(cnt_written),
    .start_acc(start_acc), .cmpl(cmpl), .irq_ack(irq_ack),
    .status(status), .int_reason(int_reason), .irq(irq)
  );

  a_r7_completion_picture: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status[4] && irq && int_reason == REASON_BUS_SVC &&
              cnt_lo == '0 && cnt_mid == '0 && seq_val == '0 && flags_val == '0));
  a_r5_start_clears_tc: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !status[4]));
endmodule

// File: tb/dmac_top_tb_top.sv
`timescale 1ns/1ps
module dmac_top_tb_top;
  logic clk, rst_n;
  logic reg_wr, phase_ld, cmd_phase, start, dma_ack, src_short, irq_ack;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [17:0] phase_val;
  logic dma_req, dma_dir, busy, done, irq;
  logic [16:0] bytes_left;
  logic [17:0] phase_size;
  logic [7:0] status, int_reason, seq_val, flags_val, cnt_lo, cnt_mid;

  int checks = 0;
  int fails  = 0;

  dmac_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .phase_ld(phase_ld), .phase_val(phase_val),
    .cmd_phase(cmd_phase), .start(start), .dma_req(dma_req), .dma_ack(dma_ack),
    .dma_dir(dma_dir), .src_short(src_short), .irq_ack(irq_ack), .busy(busy),
    .done(done), .irq(irq), .bytes_left(bytes_left), .phase_size(phase_size),
    .status(status), .int_reason(int_reason), .seq_val(seq_val),
    .flags_val(flags_val), .cnt_lo(cnt_lo), .cnt_mid(cnt_mid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ph();
    return int'($signed(phase_size));
  endfunction

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic load_phase(int v);
    phase_ld = 1'b1; phase_val = 18'(v);
    tick();
    phase_ld = 1'b0;
  endtask

  task automatic go(logic cmd);
    cmd_phase = cmd; start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic move(int n);
    dma_ack = 1'b1;
    for (int i = 0; i < n; i++) tick();
    dma_ack = 1'b0;
  endtask

  task automatic check_done(string req);
    chk({req, " done"}, int'(done), 1);
    chk({req, " status"}, int'(status), 8'h90);
    chk({req, " irq"}, int'(irq), 1);
    chk({req, " reason"}, int'(int_reason), 8'h10);
    chk({req, " counts"}, int'({cnt_mid, cnt_lo}), 0);
    chk({req, " busy"}, int'(busy), 0);
  endtask

  task automatic t_reset();
    chk("R11 busy", int'(busy), 0);
    chk("R11 status", int'(status), 0);
    chk("R11 reason", int'(int_reason), 0);
    chk("R11 irq", int'(irq), 0);
    chk("R11 left", int'(bytes_left), 0);
    chk("R11 phase", ph(), 0);
    chk("R11 regs", int'({cnt_lo, cnt_mid, seq_val, flags_val}), 0);
  endtask

  task automatic t_cmd_cap();
    wr(2'd0, 8'h40);
    wr(2'd1, 8'h00);
    load_phase(100);
    go(1'b1);
    chk("R3 cap 32", int'(bytes_left), 32);
    chk("R5 busy", int'(busy), 1);
    chk("R5 req", int'(dma_req), 1);
    move(32);
    chk("R6 left 0", int'(bytes_left), 0);
    chk("R3 phase untouched", ph(), 100);
    tick();
    check_done("R7 cmd");
    tick();
    chk("R7 done pulse", int'(done), 0);
  endtask

  task automatic t_tc_write_and_ack();
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
    chk("R10 status", int'(status), 8'h10);
    chk("R10 irq", int'(irq), 0);
    chk("R10 reason kept", int'(int_reason), 8'h10);
    wr(2'd0, 8'h05);
    chk("R2 tc cleared", int'(status), 0);
  endtask

  task automatic t_from_device();
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h05);
    wr(2'd3, 8'h03);
    chk("R2 seq", int'(seq_val), 5);
    chk("R2 flags", int'(flags_val), 3);
    load_phase(10);
    go(1'b0);
    chk("R4 min to phase", int'(bytes_left), 10);
    chk("R6 dir from device", int'(dma_dir), 0);
    move(4);
    chk("R6 left", int'(bytes_left), 6);
    chk("R6 phase down", ph(), 6);
    move(6);
    chk("R6 phase zero", ph(), 0);
    tick();
    check_done("R7 data");
    chk("R7 seq flags", int'({seq_val, flags_val}), 0);
  endtask

  task automatic t_to_device();
    irq_ack = 1'b1;
    wr(2'd0, 8'h03);
    irq_ack = 1'b0;
    load_phase(-8);
    go(1'b0);
    chk("R5 start clears tc", int'(status), 0);
    chk("R4 count smaller", int'(bytes_left), 3);
    chk("R6 dir to device", int'(dma_dir), 1);
    move(3);
    chk("R6 phase up", ph(), -5);
    tick();
    check_done("R7 to device");
  endtask

  task automatic t_mid_busy_short();
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h01);
    load_phase(1000);
    go(1'b0);
    chk("R1 mid weight", int'(bytes_left), 258);
    wr(2'd0, 8'h01);
    go(1'b1);
    chk("R9 restart ignored", int'(bytes_left), 258);
    chk("R9 still busy", int'(busy), 1);
    move(2);
    chk("R6 left", int'(bytes_left), 256);
    dma_ack = 1'b1; src_short = 1'b1;
    tick();
    dma_ack = 1'b0; src_short = 1'b0;
    check_done("R8 short");
    chk("R8 last byte counted", ph(), 997);
  endtask

  task automatic t_zero_count();
    load_phase(70000);
    go(1'b0);
    chk("R1 zero is 65536", int'(bytes_left), 65536);
    src_short = 1'b1;
    tick();
    src_short = 1'b0;
    chk("R8 short done", int'(done), 1);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0; phase_ld = 0; phase_val = 0;
    cmd_phase = 0; start = 0; dma_ack = 0; src_short = 0; irq_ack = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_cmd_cap();
    t_tc_write_and_ack();
    t_from_device();
    t_to_device();
    t_mid_busy_short();
    t_zero_count();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule